// File: doc/BRIEF.md
# Ping-Pong Projection Line Buffer

This block sits between the filter stage and the back-projection stage of a
tomographic reconstruction pipeline. It holds two equal banks of block-RAM
style storage. The filter streams one angle's filtered samples into the bank
that is currently being filled. At the same time, the back-projection stage
reads the bank that holds the previous angle, in whatever address order it
needs. When an angle's row is complete, the two banks swap roles. Writing of
one angle therefore overlaps completely with random reads of the one before.

Each bank stores `ROW_LEN` signed samples of `SAMPLE_W` bits (18 by default).
The address width is the base-2 logarithm of `ROW_LEN`, rounded up. A row
closes either on a sample flagged as the last one, or when the `ROW_LEN`-th
sample of the row arrives, whichever comes first. Reads have a fixed latency
of one clock. Before the first row has been completed, reads are reported as
invalid. Reset clears the control state only. The stored samples are not
cleared.

Top module: `proj_pingpong_buf`

## Requirements
- R1: Synchronous active-high reset drives `bank_ready` and `rd_valid` low and `rd_data` to zero. The first row written after reset is the one that later becomes readable.
- R2: Every cycle with `wr_valid` high stores `wr_data` at the next address of the bank being filled, counting up from address 0 for each row. While `wr_valid` is low, `wr_data` and `wr_last` have no effect.
- R3: A row closes on a sample with `wr_valid` and `wr_last` both high, or on the `ROW_LEN`-th sample of the row even without `wr_last`. The next sample goes to address 0 of the other bank.
- R4: The roles swap on the clock edge that stores the closing sample. A read presented in that same cycle still returns the older row. A read presented in the following cycle returns the row just closed.
- R5: `rd_addr` and `rd_en` are sampled on the rising edge. The matching `rd_data` and `rd_valid` are present during the next cycle.
- R6: Reads may use any address order, and each read returns the stored sample for that address.
- R7: Writes to the filling bank in the same cycles as reads of the other bank do not disturb the data that is read.
- R8: `bank_ready` rises on the edge that closes the first row after reset and stays high until the next reset.
- R9: `rd_valid` is low and `rd_data` is zero in the cycle after a read presented with `rd_en` low, with `bank_ready` low, or with `rd_addr` at or above `ROW_LEN`.
- R10: A row closed early by `wr_last` leaves the higher addresses of its bank holding their older contents.
- R11: The extreme signed values -131072 and 131071 (18 bits) and mixed-sign samples are returned bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write sample strobe |
| wr_last | input | 1 | Marks the final sample of an angle's row |
| wr_data | input | SAMPLE_W | Signed filtered sample |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address within the completed row |
| rd_data | output | SAMPLE_W | Signed sample, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a valid sample |
| bank_ready | output | 1 | At least one full row is available |

## Verification
The hardest moments to reach are the cycle in which the closing sample is written while a read is in flight, and a short row that leaves data from two angles earlier in the upper addresses. The bench drives the read and write ports together, cycle by cycle. It sends one read with the closing sample and another right after it, so both sides of the swap are observed. It then sends a short row followed by a full sweep of reads, so the old and new halves of that bank are both checked against a model of the two banks kept in the bench.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // Identity of one of the two storage banks.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // The bank opposite to the given one.
  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

  // Address width needed to index a row of the given length.
  function automatic int row_addr_w(input int row_len);
    return (row_len <= 2) ? 1 : $clog2(row_len);
  endfunction

endpackage

// File: rtl/pp_bank_ram.sv
// One storage bank: one write port and one registered read port, in a form
// that maps onto an FPGA block RAM.
module pp_bank_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // The read register has no reset, so the block RAM output register
  // can absorb it.
  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/pp_row_writer.sv
// Tracks the write position within the row being filled, picks the bank
// being filled, and raises the ready flag once the first row is complete.
module pp_row_writer
  import pp_pkg::*;
#(
  parameter int ROW_LEN = 183,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_last,
  output logic [ADDR_W-1:0] wr_addr,
  output bank_e             fill_bank,
  output logic              row_close,
  output logic              ready
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ROW_LEN - 1);

  logic at_end;

  // A row ends on the marker or when the row is full.
  always_comb begin
    at_end    = (wr_addr == LAST_ADDR);
    row_close = wr_valid && (wr_last || at_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
    end else if (wr_valid) begin
      wr_addr <= row_close ? '0 : wr_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_bank <= BANK_A;
    end else if (row_close) begin
      fill_bank <= other_bank(fill_bank);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
    end else if (row_close) begin
      ready <= 1'b1;
    end
  end

endmodule

// File: rtl/pp_read_side.sv
// Registers which bank answers a read and whether the read is valid, then
// picks that bank's registered output.
module pp_read_side
  import pp_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int ROW_LEN = 183,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  bank_e             read_bank,
  input  logic              ready,
  input  logic [DATA_W-1:0] bank_q [2],
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int SPAN = 1 << ADDR_W;

  logic  in_range;
  bank_e sel_q;
  logic  valid_q;

  // An address compare is only needed when the row does not fill the
  // power-of-two address space.
  generate
    if (ROW_LEN < SPAN) begin : g_range_chk
      always_comb in_range = (int'(rd_addr) < ROW_LEN);
    end else begin : g_full_span
      always_comb in_range = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sel_q   <= BANK_A;
    end else begin
      valid_q <= rd_en && ready && in_range;
      sel_q   <= read_bank;
    end
  end

  always_comb begin
    rd_valid = valid_q;
    rd_data  = valid_q ? bank_q[sel_q] : '0;
  end

endmodule

// File: rtl/proj_pingpong_buf.sv
module proj_pingpong_buf
  import pp_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int ROW_LEN  = 183,
  localparam int ADDR_W  = row_addr_w(ROW_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic                wr_last,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                bank_ready
);

  logic [ADDR_W-1:0]   wr_addr;
  bank_e               fill_bank;
  bank_e               read_bank;
  logic                row_close;
  logic                ready;
  logic [SAMPLE_W-1:0] bank_q [2];

  pp_row_writer #(
    .ROW_LEN (ROW_LEN),
    .ADDR_W  (ADDR_W)
  ) u_writer (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_last   (wr_last),
    .wr_addr   (wr_addr),
    .fill_bank (fill_bank),
    .row_close (row_close),
    .ready     (ready)
  );

  always_comb read_bank = other_bank(fill_bank);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic we_b;
    always_comb we_b = wr_valid && (fill_bank == bank_e'(b));
    pp_bank_ram #(
      .DATA_W (SAMPLE_W),
      .ADDR_W (ADDR_W)
    ) u_ram (
      .clk   (clk),
      .we    (we_b),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (bank_q[b])
    );
  end

  pp_read_side #(
    .DATA_W  (SAMPLE_W),
    .ROW_LEN (ROW_LEN),
    .ADDR_W  (ADDR_W)
  ) u_reader (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .read_bank (read_bank),
    .ready     (ready),
    .bank_q    (bank_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  always_comb bank_ready = ready;

endmodule

// File: rtl/pp_buf_checker.sv
module pp_buf_checker #(
  parameter int SAMPLE_W = 18,
  parameter int ROW_LEN  = 183,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_valid,
  input logic                wr_last,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [SAMPLE_W-1:0] rd_data,
  input logic                rd_valid,
  input logic                bank_ready,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic                fill_bit
);

  // R2: the write position never leaves the row.
  a_r2_addr_in_row: assert property (@(posedge clk) disable iff (rst)
    int'(wr_addr) < ROW_LEN);

  // R3: closing a row hands the filling role to the other bank.
  a_r3_close_swaps: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_last || int'(wr_addr) == ROW_LEN - 1)) |=> (fill_bit != $past(fill_bit)));

  // R2: without a write strobe the banks keep their roles.
  a_r2_idle_no_swap: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(fill_bit));

  // R8: once ready, the flag stays until reset.
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (rst)
    bank_ready |=> bank_ready);

  // R9: a valid read needs a request, readiness and an in-range address.
  a_r9_valid_cause: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && $past(bank_ready) && int'($past(rd_addr)) < ROW_LEN));

  // R9: invalid reads present zero.
  a_r9_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

endmodule

bind proj_pingpong_buf pp_buf_checker #(
  .SAMPLE_W (SAMPLE_W),
  .ROW_LEN  (ROW_LEN),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_last    (wr_last),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .bank_ready (bank_ready),
  .wr_addr    (wr_addr),
  .fill_bit   (fill_bank)
);

// File: tb/test_proj_pingpong_buf.sv
module test_proj_pingpong_buf;

  localparam int SW   = 18;
  localparam int RL   = 13;
  localparam int AW   = 4;
  localparam int SPAN = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_last = 1'b0;
  logic [SW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [SW-1:0] rd_data;
  logic          rd_valid;
  logic          bank_ready;

  int errors = 0;
  int checks = 0;

  // Model of the two banks, built from the requirements.
  logic [SW-1:0] m_mem [2][SPAN];
  int            m_fill = 0;
  int            m_ptr = 0;
  bit            m_ready = 0;

  always #5 clk = ~clk;

  proj_pingpong_buf #(.SAMPLE_W(SW), .ROW_LEN(RL)) i_proj_pingpong_buf (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_last(wr_last),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .bank_ready(bank_ready)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pat(input int row, input int i);
    return SW'(row * 9001 + i * 317 - 60000);
  endfunction

  // One clock: drive both ports, check the read result one cycle later.
  task automatic step(input bit wv, input logic [SW-1:0] wd, input bit wl,
                      input bit re, input int ra, input string tag);
    bit            ev;
    logic [SW-1:0] ed;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_last = wl;
    rd_en = re; rd_addr = AW'(ra);
    ev = re && m_ready && (ra < RL);
    ed = ev ? m_mem[1 - m_fill][ra] : '0;
    @(posedge clk); #1;
    if (re) begin
      check(rd_valid == ev, {tag, " valid"}, rd_valid, ev);
      check(rd_data == ed, {tag, " data"}, $signed(rd_data), $signed(ed));
    end
    if (wv) begin
      m_mem[m_fill][m_ptr] = wd;
      if (wl || m_ptr == RL - 1) begin
        m_ptr = 0; m_fill = 1 - m_fill; m_ready = 1;
      end else m_ptr++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_valid = 0; wr_last = 0; rd_en = 0;
    @(posedge clk); @(posedge clk); #1;
    m_fill = 0; m_ptr = 0; m_ready = 0;
    check(bank_ready == 0, "R1 ready after reset", bank_ready, 0);
    check(rd_valid == 0, "R1 valid after reset", rd_valid, 0);
    check(rd_data == 0, "R1 data after reset", rd_data, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    step(0, '0, 0, 1, 3, "R9 read before ready");
    check(bank_ready == 0, "R8 not ready yet", bank_ready, 0);
  endtask

  task automatic t_first_row();
    for (int i = 0; i < RL; i++) step(1, pat(1, i), i == RL - 1, 0, 0, "R2");
    check(bank_ready == 1, "R8 ready after first row", bank_ready, 1);
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, (i * 5) % RL, "R6 R5 permuted read");
  endtask

  task automatic t_overlap();
    // The last iteration reads in the closing cycle and must see the old row.
    for (int i = 0; i < RL; i++)
      step(1, pat(2, i), i == RL - 1, 1, (i * 7 + 3) % RL, "R7 R4 overlap read");
    step(0, '0, 0, 1, 4, "R4 read after swap");
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, RL - 1 - i, "R6 reverse read");
  endtask

  task automatic t_short_row();
    for (int i = 0; i < 5; i++) step(1, pat(3, i), i == 4, 0, 0, "R3 short row");
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, i, "R10 short row tail");
  endtask

  task automatic t_auto_close();
    for (int i = 0; i < RL; i++) step(1, pat(4, i), 0, 1, i % 5, "R3 auto close");
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, (i * 3) % RL, "R3 after auto close");
  endtask

  task automatic t_idle_ignore();
    for (int i = 0; i < 6; i++) step(0, pat(9, i), 1, 1, i * 2, "R2 idle marker ignored");
    step(1, pat(5, 0), 1, 1, 0, "R2 single sample row");
    step(0, '0, 0, 1, 0, "R2 single sample readback");
    step(0, '0, 0, 1, 1, "R10 single sample tail");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < RL; i++) begin
      logic [SW-1:0] v;
      v = (i % 3 == 0) ? 18'h20000 : (i % 3 == 1) ? 18'h1FFFF : pat(6, i);
      step(1, v, i == RL - 1, 0, 0, "R11 write");
    end
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, i, "R11 extreme read");
  endtask

  task automatic t_range();
    step(0, '0, 0, 1, RL, "R9 address at row length");
    step(0, '0, 0, 1, SPAN - 1, "R9 top address");
    step(0, '0, 0, 0, 2, "R9 no request");
    check(rd_valid == 0, "R9 no request valid", rd_valid, 0);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) step(1, pat(7, i), 0, 0, 0, "R1 partial row");
    do_reset();
    step(0, '0, 0, 1, 0, "R1 read after reset");
    for (int i = 0; i < RL; i++) step(1, pat(8, i), i == RL - 1, 0, 0, "R1 row after reset");
    check(bank_ready == 1, "R8 ready again", bank_ready, 1);
    for (int i = 0; i < RL; i++) step(0, '0, 0, 1, i, "R1 first row readable");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_row();
    t_overlap();
    t_short_row();
    t_auto_close();
    t_idle_ignore();
    t_extremes();
    t_range();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule